// File: doc/BRIEF.md
# Immediate Integer Arithmetic Unit

This unit executes the immediate-operand integer instructions of a 32-bit load/store processor pipeline. Each instruction combines one source register value with a 16-bit signed constant. The operations are plain add, add with the constant moved into the upper half, add with carry capture, add with carry capture plus a condition-field update, reverse subtract with carry, and low-half multiply with overflow detection. Decode and the register file sit outside the unit. It receives an already decoded operation code, the source register number, that register's value and the constant.

For the three add families, a source register number of zero means the literal value zero and not the contents of register zero. Reverse subtract and multiply always use the supplied value. The result and the flag updates appear on registered outputs one clock after a valid strobe. The carry, overflow and sticky summary-overflow flags, and the 4-bit condition field, are held inside the unit. They keep their values until an operation that writes them.

Top module: `imm_alu_unit`

## Requirements
- R1: The operation code `op_i` is 3 bits wide: 0 add, 1 add-upper, 2 add-carry, 3 add-carry-record, 4 reverse-subtract, 5 multiply. For code 0, the result is A plus the sign-extended constant, where A is zero when `ra_idx_i` is 0 and `ra_val_i` otherwise.
- R2: For code 1, the result is A (with the same zero rule) plus the constant shifted left by 16 bits.
- R3: For code 2, the result is the code-0 sum, and `ca_o` takes the carry out of bit 31.
- R4: Code 3 gives the same result and carry as code 2. It also loads `cr_o` with bit 3 = result negative, bit 2 = result positive and nonzero, bit 1 = result zero, and bit 0 = the current `so_o`. It also pulses `cr_we_o` for one cycle.
- R5: For code 4, the result is the bitwise inverse of `ra_val_i`, plus the sign-extended constant, plus one. `ca_o` takes the carry out of that sum, and no zero substitution applies.
- R6: For code 5, the result is the low 32 bits of the signed product of `ra_val_i` and the constant. `ov_o` is set when that product does not fit in 32 signed bits and cleared otherwise. `so_o` is ORed with the new overflow and stays set until reset.
- R7: Codes 0 and 1 leave `ca_o` and `ov_o` unchanged. Code 5 leaves `ca_o` unchanged. Only code 3 changes `cr_o`.
- R8: `valid_o` is high exactly one cycle after each cycle with `valid_i` high. When `valid_i` is low, the result and all flags hold their values.
- R9: While `rst_n` is low, `valid_o`, `result_o`, `ca_o`, `ov_o`, `so_o`, `cr_o` and `cr_we_o` are all zero.
- R10: Codes 6 and 7 produce a valid pulse with result zero and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| ra_idx_i | input | 5 | Source register number (0 selects literal zero for adds) |
| ra_val_i | input | 32 | Source register value |
| imm_i | input | 16 | Signed immediate |
| valid_o | output | 1 | Result valid, one cycle after strobe |
| result_o | output | 32 | Registered result |
| ca_o | output | 1 | Carry flag |
| ov_o | output | 1 | Overflow flag |
| so_o | output | 1 | Sticky summary-overflow flag |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr_we_o | output | 1 | Condition field updated this cycle |

## Verification
The assertions check the following on every cycle: the strobe-to-valid latency, that flags and result hold between strobes, that summary overflow is sticky, that add and add-upper do not disturb carry and overflow, and that the condition field is self-consistent whenever it is written. The arithmetic values themselves can only be shown by the bench's scenarios. These include the zero-register substitution, carry out of the reverse subtract, and multiply overflow at both signed extremes, where -2^31 must fit but +2^31 must not.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD     = 3'd0,
      OP_ADD_UP  = 3'd1,
      OP_ADD_CA  = 3'd2,
      OP_ADD_REC = 3'd3,
      OP_RSUB    = 3'd4,
      OP_MUL     = 3'd5
   } imm_op_e;

   localparam int CR_BITS = 4;
   localparam int CR_LT   = 3;
   localparam int CR_GT   = 2;
   localparam int CR_EQ   = 1;
   localparam int CR_SO   = 0;

endpackage

// File: rtl/imm_alu_operand.sv
module imm_alu_operand
   import imm_alu_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16,
   parameter int IDX_W = 5
) (
   input  imm_op_e           op_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [XLEN-1:0]   val_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [XLEN-1:0]   opa_o,
   output logic [XLEN-1:0]   opb_o,
   output logic              cin_o,
   output logic [XLEN-1:0]   simm_o
);
   localparam int EXT_W = XLEN - IMM_W;

   logic [XLEN-1:0] a_or_zero;
   logic [XLEN-1:0] imm_sext;
   logic [XLEN-1:0] imm_upper;

   if (XLEN <= IMM_W) begin : g_width_bad
      $error("imm_alu_operand: XLEN must exceed IMM_W");
   end

   assign imm_sext  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   assign imm_upper = imm_sext << IMM_W;
   assign a_or_zero = (idx_i == '0) ? '0 : val_i;
   assign simm_o    = imm_sext;

   always_comb begin
      opa_o = a_or_zero;
      opb_o = imm_sext;
      cin_o = 1'b0;
      unique case (op_i)
         OP_ADD_UP: opb_o = imm_upper;
         OP_RSUB: begin
            opa_o = ~val_i;
            cin_o = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/imm_alu_adder.sv
module imm_alu_adder #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            cin_i,
   output logic [XLEN-1:0] sum_o,
   output logic            cout_o
);
   localparam int SW = XLEN + 1;

   logic [SW-1:0] wide;

   assign wide   = {1'b0, a_i} + {1'b0, b_i} + SW'(cin_i);
   assign sum_o  = wide[XLEN-1:0];
   assign cout_o = wide[XLEN];
endmodule

// File: rtl/imm_alu_mul.sv
module imm_alu_mul #(
   parameter int XLEN      = 32,
   parameter int IMM_W     = 16,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic [XLEN-1:0]  a_i,
   input  logic [IMM_W-1:0] b_i,
   output logic [XLEN-1:0]  lo_o,
   output logic             ov_o
);
   localparam int PW = XLEN + IMM_W;

   logic [PW-1:0] a_ext;
   logic [PW-1:0] b_ext;
   logic [PW-1:0] prod;

   assign a_ext = {{IMM_W{a_i[XLEN-1]}}, a_i};
   assign b_ext = {{XLEN{b_i[IMM_W-1]}}, b_i};

   if (SHIFT_ADD) begin : g_shift_add
      always_comb begin
         prod = '0;
         for (int i = 0; i < IMM_W - 1; i++) begin
            if (b_i[i]) prod = prod + (a_ext << i);
         end
         if (b_i[IMM_W-1]) prod = prod - (a_ext << (IMM_W - 1));
      end
   end else begin : g_native
      assign prod = a_ext * b_ext;
   end

   assign lo_o = prod[XLEN-1:0];
   assign ov_o = (prod[PW-1:XLEN-1] != '0) && (prod[PW-1:XLEN-1] != '1);
endmodule

// File: rtl/imm_alu_cr.sv
module imm_alu_cr
   import imm_alu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0]    res_i,
   input  logic               so_i,
   output logic [CR_BITS-1:0] cr_o
);
   logic neg, zero;

   assign neg  = res_i[XLEN-1];
   assign zero = (res_i == '0);

   always_comb begin
      cr_o        = '0;
      cr_o[CR_LT] = neg;
      cr_o[CR_GT] = !neg && !zero;
      cr_o[CR_EQ] = zero;
      cr_o[CR_SO] = so_i;
   end
endmodule

// File: rtl/imm_alu_unit.sv
module imm_alu_unit
   import imm_alu_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int IMM_W     = 16,
   parameter int IDX_W     = 5,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [2:0]       op_i,
   input  logic [IDX_W-1:0] ra_idx_i,
   input  logic [XLEN-1:0]  ra_val_i,
   input  logic [IMM_W-1:0] imm_i,
   output logic             valid_o,
   output logic [XLEN-1:0]  result_o,
   output logic             ca_o,
   output logic             ov_o,
   output logic             so_o,
   output logic [3:0]       cr_o,
   output logic             cr_we_o
);
   imm_op_e         op;
   logic [XLEN-1:0] opa, opb, simm, sum, prod;
   logic            cin, cout, mul_ov;
   logic [XLEN-1:0] res_n;
   logic [CR_BITS-1:0] cr_n;
   logic            wr_ca, is_mul, is_rec;

   if (IDX_W < 1) begin : g_idx_bad
      $error("imm_alu_unit: IDX_W must be at least 1");
   end

   assign op = imm_op_e'(op_i);

   imm_alu_operand #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) i_opnd (
      .op_i(op), .idx_i(ra_idx_i), .val_i(ra_val_i), .imm_i(imm_i),
      .opa_o(opa), .opb_o(opb), .cin_o(cin), .simm_o(simm)
   );

   imm_alu_adder #(.XLEN(XLEN)) i_add (
      .a_i(opa), .b_i(opb), .cin_i(cin), .sum_o(sum), .cout_o(cout)
   );

   imm_alu_mul #(.XLEN(XLEN), .IMM_W(IMM_W), .SHIFT_ADD(SHIFT_ADD)) i_mul (
      .a_i(ra_val_i), .b_i(imm_i), .lo_o(prod), .ov_o(mul_ov)
   );

   imm_alu_cr #(.XLEN(XLEN)) i_cr (
      .res_i(sum), .so_i(so_o), .cr_o(cr_n)
   );

   always_comb begin
      res_n  = '0;
      wr_ca  = 1'b0;
      is_mul = 1'b0;
      is_rec = 1'b0;
      case (op)
         OP_ADD, OP_ADD_UP: res_n = sum;
         OP_ADD_CA, OP_RSUB: begin
            res_n = sum;
            wr_ca = 1'b1;
         end
         OP_ADD_REC: begin
            res_n  = sum;
            wr_ca  = 1'b1;
            is_rec = 1'b1;
         end
         OP_MUL: begin
            res_n  = prod;
            is_mul = 1'b1;
         end
         default: res_n = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o  <= 1'b0;
         result_o <= '0;
         ca_o     <= 1'b0;
         ov_o     <= 1'b0;
         so_o     <= 1'b0;
         cr_o     <= '0;
         cr_we_o  <= 1'b0;
      end else begin
         valid_o <= valid_i;
         cr_we_o <= 1'b0;
         if (valid_i) begin
            result_o <= res_n;
            if (wr_ca) ca_o <= cout;
            if (is_mul) begin
               ov_o <= mul_ov;
               so_o <= so_o | mul_ov;
            end
            if (is_rec) begin
               cr_o    <= cr_n;
               cr_we_o <= 1'b1;
            end
         end
      end
   end

   // R8
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (valid_o == $past(valid_i)));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(valid_i)) |->
         ($stable(result_o) && $stable(ca_o) && $stable(ov_o) && $stable(so_o) && $stable(cr_o)));

   // R6
   so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(so_o)) |-> so_o);

   // R7
   add_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(valid_i) && ($past(op_i) <= 3'd1)) |->
         ($stable(ca_o) && $stable(ov_o)));

   // R4
   cr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cr_we_o == ($past(valid_i) && ($past(op_i) == 3'd3))));

   // R4
   cr_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we_o |-> ($onehot(cr_o[3:1]) && (cr_o[1] == (result_o == '0))
                   && (cr_o[3] == result_o[XLEN-1]) && (cr_o[0] == so_o)));

   // R10
   unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(valid_i) && ($past(op_i) >= 3'd6)) |->
         ((result_o == '0) && $stable(ca_o) && $stable(ov_o) && $stable(so_o) && $stable(cr_o)));
endmodule

// File: tb/test_imm_alu_unit.sv
module test_imm_alu_unit;

   typedef struct packed {
      logic [2:0]  op;
      logic [4:0]  idx;
      logic [31:0] val;
      logic [15:0] imm;
      logic [31:0] res;
      logic        ca;
      logic        ov;
      logic        so;
      logic [3:0]  cr;
      logic        we;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t TBL [NV] = '{
      // R1 add, nonzero and zero register
      '{3'd0, 5'd3, 32'h0000_0010, 16'h0005, 32'h0000_0015, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0},
      '{3'd0, 5'd0, 32'h1234_5678, 16'hFFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0},
      // R2 add-upper
      '{3'd1, 5'd4, 32'h0000_1000, 16'h0001, 32'h0001_1000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0},
      '{3'd1, 5'd0, 32'hDEAD_BEEF, 16'h8000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0},
      // R3 add-carry
      '{3'd2, 5'd2, 32'hFFFF_FFFF, 16'h0001, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0},
      '{3'd2, 5'd2, 32'h0000_0005, 16'hFFFE, 32'h0000_0003, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0},
      // R7 add-upper keeps carry set
      '{3'd1, 5'd5, 32'h0000_0000, 16'h0002, 32'h0002_0000, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0},
      '{3'd2, 5'd2, 32'h0000_0001, 16'h0001, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0},
      // R4 record form: EQ, LT, GT
      '{3'd3, 5'd1, 32'h0000_0001, 16'hFFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'h2, 1'b1},
      '{3'd3, 5'd1, 32'h8000_0000, 16'h0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'h8, 1'b1},
      '{3'd3, 5'd1, 32'h0000_0005, 16'h0001, 32'h0000_0006, 1'b0, 1'b0, 1'b0, 4'h4, 1'b1},
      // R7 add leaves condition field
      '{3'd0, 5'd3, 32'h0000_0001, 16'h0000, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'h4, 1'b0},
      // R5 reverse subtract
      '{3'd4, 5'd6, 32'h0000_0005, 16'h000A, 32'h0000_0005, 1'b1, 1'b0, 1'b0, 4'h4, 1'b0},
      '{3'd4, 5'd6, 32'h0000_000A, 16'h0005, 32'hFFFF_FFFB, 1'b0, 1'b0, 1'b0, 4'h4, 1'b0},
      '{3'd4, 5'd0, 32'h0000_0003, 16'h0003, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'h4, 1'b0},
      // R6 multiply
      '{3'd5, 5'd7, 32'h0000_0007, 16'hFFFD, 32'hFFFF_FFEB, 1'b1, 1'b0, 1'b0, 4'h4, 1'b0},
      '{3'd5, 5'd7, 32'h0001_0000, 16'h7FFF, 32'h7FFF_0000, 1'b1, 1'b0, 1'b0, 4'h4, 1'b0},
      '{3'd5, 5'd7, 32'h0002_0000, 16'h4000, 32'h8000_0000, 1'b1, 1'b1, 1'b1, 4'h4, 1'b0},
      // R7 add leaves overflow
      '{3'd0, 5'd3, 32'h0000_0002, 16'h0002, 32'h0000_0004, 1'b1, 1'b1, 1'b1, 4'h4, 1'b0},
      '{3'd5, 5'd7, 32'h0000_0003, 16'h0002, 32'h0000_0006, 1'b1, 1'b0, 1'b1, 4'h4, 1'b0},
      // R4 summary overflow copied into field
      '{3'd3, 5'd1, 32'h0000_0005, 16'h0001, 32'h0000_0006, 1'b0, 1'b0, 1'b1, 4'h5, 1'b1},
      // R6 signed extremes
      '{3'd5, 5'd7, 32'h4000_0000, 16'hFFFE, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 4'h5, 1'b0},
      '{3'd5, 5'd7, 32'h8000_0000, 16'hFFFF, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 4'h5, 1'b0},
      // R10 unused codes
      '{3'd6, 5'd2, 32'hFFFF_FFFF, 16'h0001, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 4'h5, 1'b0},
      '{3'd7, 5'd2, 32'h0000_0009, 16'h0009, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 4'h5, 1'b0},
      // R5 carry from reverse subtract with idx 0
      '{3'd4, 5'd0, 32'h0000_0000, 16'h0000, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 4'h5, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic [4:0]  ra_idx_i = '0;
   logic [31:0] ra_val_i = '0;
   logic [15:0] imm_i = '0;
   logic        valid_o, ca_o, ov_o, so_o, cr_we_o;
   logic [31:0] result_o;
   logic [3:0]  cr_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   imm_alu_unit i_imm_alu_unit (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
      .ra_idx_i(ra_idx_i), .ra_val_i(ra_val_i), .imm_i(imm_i),
      .valid_o(valid_o), .result_o(result_o), .ca_o(ca_o), .ov_o(ov_o),
      .so_o(so_o), .cr_o(cr_o), .cr_we_o(cr_we_o)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_state(input string req, input vec_t v, input logic vld);
      check(req, "valid_o", 32'(valid_o), 32'(vld));
      check(req, "result_o", result_o, v.res);
      check(req, "ca_o", 32'(ca_o), 32'(v.ca));
      check(req, "ov_o", 32'(ov_o), 32'(v.ov));
      check(req, "so_o", 32'(so_o), 32'(v.so));
      check(req, "cr_o", 32'(cr_o), 32'(v.cr));
      check(req, "cr_we_o", 32'(cr_we_o), 32'(v.we));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check_state("R9", '0, 1'b0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         op_i     = TBL[k].op;
         ra_idx_i = TBL[k].idx;
         ra_val_i = TBL[k].val;
         imm_i    = TBL[k].imm;
         valid_i  = 1'b1;
         @(negedge clk);
         valid_i  = 1'b0;
         check_state($sformatf("vec%0d", k), TBL[k], 1'b1);
      end

      // R8 no strobe: an operation that would write carry must not land
      op_i = 3'd2; ra_idx_i = 5'd2; ra_val_i = 32'h0000_0001; imm_i = 16'h0001;
      valid_i = 1'b0;
      @(negedge clk);
      check_state("R8", TBL[NV-1], 1'b0);
      @(negedge clk);
      check_state("R8", TBL[NV-1], 1'b0);

      // R9 reset mid-run clears sticky and field
      rst_n = 1'b0;
      @(negedge clk);
      check_state("R9", '0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "so_o after release", 32'(so_o), 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule